// File: doc/BRIEF.md
# Dual-Edge Command Splitter with Coarse Delay

This block takes a single serial input that carries two interleaved 40 Mb/s streams. During the high half of each bunch-clock period the line holds a command bit. During the low half it holds a trigger bit. The block runs on a clock four times the bunch rate, one 6.25 ns coarse step per cycle. It derives the bunch clock internally as a 4-step period. The command bit is sampled at the rising bunch edge and the trigger bit at the falling edge. Both bits are presented as registered values with one-step strobes, and the command bit also feeds the internal command decoder.

Both captured bits are then put back onto one output line, command in the high half and trigger in the low half, with their content unchanged. That line passes through a synchronous delay line whose tap can be set from 0 to 15 coarse steps, so the delay range covers more than a whole bunch period. A new tap setting is taken only at a period boundary. A synchronous reset clears every stage, so no false trigger can leave the block.

Top module: `cmd_trig_mux_delay`

## Requirements
- R1: `bc_o` is high for steps 0 and 1 of each 4-step period and low for steps 2 and 3. The cycle in which reset is released is step 0.
- R2: `line_i` as sampled at the end of step 0 (the rising bunch edge) appears on `cmd_bit_o` during step 1, and `cmd_stb_o` is high in step 1 only.
- R3: `line_i` as sampled at the end of step 2 (the falling bunch edge) appears on `trig_bit_o` during step 3, and `trig_stb_o` is high in step 3 only.
- R4: `cmd_bit_o` and `trig_bit_o` keep their captured values until the next capture.
- R5: When each half period of `line_i` is held constant, `line_o` equals `line_i` from 5+D cycles earlier, where D is the active delay. This puts the command in the high half and the trigger in the low half, with bits unchanged.
- R6: The value on `delay_cfg_i` during step 3 of a period becomes the active delay D from step 0 of the next period. Changes at any other step have no effect until that point.
- R7: D covers 0 to 15 steps, so the output can lag by more than one full period (4 steps).
- R8: While reset is asserted, after one clock `line_o`, both strobes and both bits are 0, and D is 0. After release, `line_o` stays 0 until delayed input data reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Coarse-step clock, four cycles per bunch period |
| rst_i | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Combined input line: command in the high half, trigger in the low half |
| delay_cfg_i | input | 4 | Requested coarse delay in steps |
| bc_o | output | 1 | Regenerated bunch clock |
| cmd_bit_o | output | 1 | Last captured command bit |
| cmd_stb_o | output | 1 | One-step pulse marking a new command bit, for the decoder |
| trig_bit_o | output | 1 | Last captured trigger bit |
| trig_stb_o | output | 1 | One-step pulse marking a new trigger bit |
| line_o | output | 1 | Recombined and delayed output line |

## Verification
The hardest case to reach is a delay change that arrives partway through a period. If the design applied it at once, `line_o` would jump to a different tap for the remaining steps of that period. The stimulus rewrites `delay_cfg_i` after the second step of a period, and sometimes rewrites it again at step 3, while the data differs from bit to bit. Any early switch of the tap therefore shows up as a wrong bit. A second reset in the middle of a run at the largest delay, followed by all-ones data, checks that the cleared pipeline emits only zeros until real data has passed through it.

// File: rtl/cmd_trig_pkg.sv
package cmd_trig_pkg;
  // steps in one bunch period for a phase counter of ph_w bits
  function automatic int unsigned period_steps(int unsigned ph_w);
    return 1 << ph_w;
  endfunction

  function automatic int unsigned half_steps(int unsigned ph_w);
    return (1 << ph_w) >> 1;
  endfunction

  // input-to-output lag in steps for an active delay d
  function automatic int unsigned line_latency(int unsigned ph_w, int unsigned d);
    return period_steps(ph_w) + 1 + d;
  endfunction
endpackage

// File: rtl/cmd_trig_phase.sv
module cmd_trig_phase #(
  parameter int unsigned PH_W = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic bc_high_o,
  output logic rise_tick_o,
  output logic fall_tick_o,
  output logic last_tick_o
);
  import cmd_trig_pkg::*;
  localparam int unsigned HALF = half_steps(PH_W);
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(HALF);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(period_steps(PH_W) - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) ph_q <= '0;
    else       ph_q <= ph_q + 1'b1;
  end

  assign bc_high_o   = (ph_q < HALF_PH);
  assign rise_tick_o = (ph_q == '0);
  assign fall_tick_o = (ph_q == HALF_PH);
  assign last_tick_o = (ph_q == LAST_PH);

  // R1: a period boundary is followed by a high bunch-clock rising step
  p_bc_start_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    last_tick_o |=> (rise_tick_o && bc_high_o));
endmodule

// File: rtl/cmd_trig_demux.sv
module cmd_trig_demux (
  input  logic clk_i,
  input  logic rst_i,
  input  logic line_i,
  input  logic bc_high_i,
  input  logic rise_tick_i,
  input  logic fall_tick_i,
  input  logic last_tick_i,
  output logic cmd_bit_o,
  output logic cmd_stb_o,
  output logic trig_bit_o,
  output logic trig_stb_o,
  output logic rec_o
);
  logic cmd_q, trig_q, cmd_stb_q, trig_stb_q;
  logic cmd_hold_q, trig_hold_q;

  // capture on each bunch edge
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmd_q      <= 1'b0;
      trig_q     <= 1'b0;
      cmd_stb_q  <= 1'b0;
      trig_stb_q <= 1'b0;
    end else begin
      cmd_stb_q  <= rise_tick_i;
      trig_stb_q <= fall_tick_i;
      if (rise_tick_i) cmd_q  <= line_i;
      if (fall_tick_i) trig_q <= line_i;
    end
  end

  // both bits frozen for a whole period before recombination
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmd_hold_q  <= 1'b0;
      trig_hold_q <= 1'b0;
    end else if (last_tick_i) begin
      cmd_hold_q  <= cmd_q;
      trig_hold_q <= trig_q;
    end
  end

  assign rec_o      = bc_high_i ? cmd_hold_q : trig_hold_q;
  assign cmd_bit_o  = cmd_q;
  assign cmd_stb_o  = cmd_stb_q;
  assign trig_bit_o = trig_q;
  assign trig_stb_o = trig_stb_q;

  // R2: the command strobe lasts a single step
  p_cmd_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cmd_stb_o |=> !cmd_stb_o);
  // R3: a trigger strobe comes two steps after a command strobe
  p_trig_order_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    trig_stb_o |-> $past(cmd_stb_o, 2));
  // R4: the command bit changes only when its strobe marks it
  p_cmd_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !cmd_stb_o |-> $stable(cmd_bit_o));
endmodule

// File: rtl/cmd_trig_delay.sv
module cmd_trig_delay #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             rec_i,
  input  logic             last_tick_i,
  input  logic [DLY_W-1:0] cfg_i,
  output logic [DLY_W-1:0] dly_act_o,
  output logic             line_o
);
  localparam int unsigned DEPTH = 1 << DLY_W;

  logic [DLY_W-1:0] d_act_q;
  logic [DEPTH-1:0] stage_q;

  // delay request taken only at a period boundary
  always_ff @(posedge clk_i) begin
    if (rst_i)            d_act_q <= '0;
    else if (last_tick_i) d_act_q <= cfg_i;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[i] <= 1'b0;
        else       stage_q[i] <= rec_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[i] <= 1'b0;
        else       stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign line_o    = stage_q[d_act_q];
  assign dly_act_o = d_act_q;

  // R6: the active delay moves only right after a boundary step
  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !last_tick_i |=> $stable(dly_act_o));
  // R5: at zero delay the line is the recombined bit one step later
  p_zero_tap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (dly_act_o == '0) |=> ((dly_act_o != '0) || (line_o == $past(rec_i))));
endmodule

// File: rtl/cmd_trig_mux_delay.sv
module cmd_trig_mux_delay #(
  parameter int unsigned PH_W  = 2,
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             line_i,
  input  logic [DLY_W-1:0] delay_cfg_i,
  output logic             bc_o,
  output logic             cmd_bit_o,
  output logic             cmd_stb_o,
  output logic             trig_bit_o,
  output logic             trig_stb_o,
  output logic             line_o
);
  logic bc_high, rise_tick, fall_tick, last_tick, rec;
  logic [DLY_W-1:0] dly_act;

  cmd_trig_phase #(.PH_W(PH_W)) u_phase (
    .clk_i(clk_i), .rst_i(rst_i), .bc_high_o(bc_high),
    .rise_tick_o(rise_tick), .fall_tick_o(fall_tick), .last_tick_o(last_tick)
  );

  cmd_trig_demux u_demux (
    .clk_i(clk_i), .rst_i(rst_i), .line_i(line_i), .bc_high_i(bc_high),
    .rise_tick_i(rise_tick), .fall_tick_i(fall_tick), .last_tick_i(last_tick),
    .cmd_bit_o(cmd_bit_o), .cmd_stb_o(cmd_stb_o), .trig_bit_o(trig_bit_o),
    .trig_stb_o(trig_stb_o), .rec_o(rec)
  );

  cmd_trig_delay #(.DLY_W(DLY_W)) u_delay (
    .clk_i(clk_i), .rst_i(rst_i), .rec_i(rec), .last_tick_i(last_tick),
    .cfg_i(delay_cfg_i), .dly_act_o(dly_act), .line_o(line_o)
  );

  assign bc_o = bc_high;

  // R8: one clock into reset the output line is quiet
  p_reset_quiet_r8: assert property (@(posedge clk_i)
    $past(rst_i) && rst_i |-> (!line_o && !cmd_stb_o && !trig_stb_o && (dly_act == '0)));
endmodule

// File: tb/test_cmd_trig_mux_delay.sv
module test_cmd_trig_mux_delay;
  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       line_i = 1'b0;
  logic [3:0] delay_cfg_i = 4'd0;
  logic bc_o, cmd_bit_o, cmd_stb_o, trig_bit_o, trig_stb_o, line_o;

  int   checks = 0;
  int   errs = 0;
  bit   run = 0;
  bit   restart = 0;
  bit   done = 0;
  bit   hist[$];
  string tag = "R5";
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk_i = ~clk_i;

  cmd_trig_mux_delay i_cmd_trig_mux_delay (
    .clk_i(clk_i), .rst_i(rst_i), .line_i(line_i), .delay_cfg_i(delay_cfg_i),
    .bc_o(bc_o), .cmd_bit_o(cmd_bit_o), .cmd_stb_o(cmd_stb_o),
    .trig_bit_o(trig_bit_o), .trig_stb_o(trig_stb_o), .line_o(line_o)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // driver: one step of input, recorded as the expected source
  task automatic drive_step(bit v);
    @(negedge clk_i);
    line_i = v;
    hist.push_back(v);
  endtask

  task automatic drive_period(bit c, bit t);
    drive_step(c); drive_step(c); drive_step(t); drive_step(t);
  endtask

  // R6: change the request partway through a period, then again at step 3
  task automatic drive_period_midcfg(bit c, bit t, logic [3:0] mid, logic [3:0] late);
    drive_step(c); drive_step(c);
    delay_cfg_i = mid;
    drive_step(t);
    delay_cfg_i = late;
    drive_step(t);
  endtask

  task automatic hold_reset(int n);
    @(negedge clk_i);
    run = 0;
    rst_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      chk("R8 line", line_o, 1'b0);
      chk("R8 cmd_stb", cmd_stb_o, 1'b0);
      chk("R8 trig_stb", trig_stb_o, 1'b0);
      chk("R8 cmd_bit", cmd_bit_o, 1'b0);
      chk("R8 trig_bit", trig_bit_o, 1'b0);
    end
  endtask

  // release in step 0; that period carries zeros
  task automatic start_run();
    @(negedge clk_i);
    rst_i = 1'b0;
    hist.delete();
    line_i = 1'b0;
    hist.push_back(1'b0);
    restart = 1;
    run = 1;
    drive_step(0); drive_step(0); drive_step(0);
  endtask

  // monitor: samples one time unit after each rising edge
  initial begin
    int k = 0;
    int d_m = 0;
    int j;
    bit last_cmd = 0;
    bit exp_line;
    forever begin
      @(posedge clk_i);
      #1;
      if (restart) begin
        k = 1; d_m = 0; last_cmd = 0; restart = 0;
      end else if (run) begin
        k++;
      end
      if (run) begin
        if (k % 4 == 0) d_m = int'(delay_cfg_i);
        chk("R1 bc", bc_o, (k % 4) < 2);
        chk("R2 cmd_stb", cmd_stb_o, (k % 4) == 1);
        chk("R3 trig_stb", trig_stb_o, (k % 4) == 3);
        if (k % 4 == 1) begin
          last_cmd = hist[k-1];
          chk("R2 cmd_bit", cmd_bit_o, hist[k-1]);
        end
        if (k % 4 == 3) chk("R3 trig_bit", trig_bit_o, hist[k-1]);
        if (k % 4 == 2 || k % 4 == 0) chk("R4 cmd hold", cmd_bit_o, last_cmd);
        j = k - 5 - d_m;
        exp_line = (j < 0) ? 1'b0 : hist[j];
        chk({tag, " line"}, line_o, exp_line);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    hold_reset(3);
    start_run();
    // R5 zero delay with mixed bits
    tag = "R5";
    drive_period(1, 0); drive_period(0, 1); drive_period(1, 1); drive_period(0, 0);
    for (int i = 0; i < 8; i++) drive_period(next_bit(), next_bit());
    // R5 moderate delay, set in step 3
    delay_cfg_i = 4'd3;
    for (int i = 0; i < 8; i++) drive_period(next_bit(), next_bit());
    // R7 longest delay and one beyond a period
    tag = "R7";
    delay_cfg_i = 4'd15;
    for (int i = 0; i < 10; i++) drive_period(next_bit(), next_bit());
    delay_cfg_i = 4'd6;
    for (int i = 0; i < 8; i++) drive_period(next_bit(), next_bit());
    // R6 requests arriving mid period
    tag = "R6";
    drive_period_midcfg(1, 0, 4'd1, 4'd9);
    drive_period_midcfg(0, 1, 4'd14, 4'd2);
    for (int i = 0; i < 6; i++) drive_period_midcfg(next_bit(), next_bit(), 4'(i * 5), 4'(i + 7));
    for (int i = 0; i < 6; i++) drive_period(next_bit(), next_bit());
    // R8 reset at full delay, then all ones: leading zeros expected
    delay_cfg_i = 4'd15;
    for (int i = 0; i < 6; i++) drive_period(1, 1);
    hold_reset(2);
    tag = "R8";
    start_run();
    for (int i = 0; i < 8; i++) drive_period(1, 1);
    for (int i = 0; i < 4; i++) drive_period(0, 1);
    @(negedge clk_i);
    run = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule